// File: doc/BRIEF.md
# Stepped Sawtooth Ramp Channel

This block produces a stepped ramp waveform for a sound expansion. Software sets three byte-wide settings: an accumulation rate, a 12-bit period, and an enable bit. A down-counting divider makes one tick every `period + 1` clocks. The accumulator responds only to every second tick. On each responding tick it adds the rate into an 8-bit sum. After six additions, the next responding tick clears the sum instead of adding. One ramp therefore spans 14 ticks, and the output frequency is clk / (14 × (period + 1)). The 5-bit sample is the top five bits of the sum.

Two inputs shared with the other channels change the timing. `halt` freezes the divider, which freezes the ramp. `shift_x16` and `shift_x256` right-shift the programmed period, by 4 bits and by 8 bits. The step sequencer is a small state machine with three states:

- `SEQ_OFF`: the channel is disabled.
- `SEQ_EVEN`: the next tick is a skip tick.
- `SEQ_ODD`: the next tick is an acting tick.

Its transitions are:

- **arm** (`SEQ_OFF`→`SEQ_EVEN`): taken on the first clock with the enable set.
- **skip** (`SEQ_EVEN`→`SEQ_ODD`): taken on a tick.
- **act** (`SEQ_ODD`→`SEQ_EVEN`): taken on a tick. It adds the rate, or clears the sum when six additions are done.
- **drop** (any state→`SEQ_OFF`): taken whenever the enable is clear.

Top module: `saw_ramp_channel`

## Requirements
- R1: A write with `wr_sel` = 0 loads `wr_data[5:0]` as the rate. `wr_data[7:6]` has no effect on the sample.
- R2: `wr_sel` = 1 loads period bits 7:0. `wr_sel` = 2 loads period bits 11:8 from `wr_data[3:0]` and the enable from `wr_data[7]`. `wr_sel` = 3 is ignored.
- R3: When not halted, the divider ticks once every (effective period + 1) clocks. With a nonzero rate, the sample can therefore change at most once every 2 × (effective period + 1) clocks.
- R4: Ticks alternate between skip and act. Counting step 0 as the first step after enabling, a skip tick leaves the sum unchanged.
- R5: An acting tick adds the rate while fewer than six additions have been made. Otherwise it clears the sum, so the ramp repeats every 14 ticks.
- R6: At step k (0 ≤ k < 14) the sample equals bits 7:3 of (rate × floor(k/2)) mod 256.
- R7: A sum that exceeds 255 wraps modulo 256 and is never clamped.
- R8: While the enable is 0, the sample is 0 and the sum is held at zero. Re-enabling restarts the ramp at step 0. With a period of 0, the first tick is skip-type, and it comes one clock after the arm clock.
- R9: While `halt` is 1, the divider and the ramp are frozen and the sample does not change.
- R10: `shift_x256` makes the effective period `period >> 8`. Otherwise `shift_x16` makes it `period >> 4`. With neither set it is `period`.
- R11: After reset, the sample is 0, and the rate, period and enable are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register select: 0 rate, 1 period low, 2 period high and enable |
| wr_data | input | 8 | Write data |
| halt | input | 1 | Freezes the divider |
| shift_x16 | input | 1 | Period right shift by 4 |
| shift_x256 | input | 1 | Period right shift by 8, takes precedence over `shift_x16` |
| sample | output | 5 | Ramp sample, bits 7:3 of the sum |

## Verification
The hardest points to reach are the divider's phase and the act/skip parity of a tick. Neither is visible at the ports. The stimulus removes both unknowns by running most checks with a period of 0, so that every clock is a tick, and by enabling the channel from a known disabled state. Step k then lands exactly k+1 clocks after the enabling write. This allows a full sweep of all 64 rates, including every wrapping rate, over more than one ramp. For the period and shift checks, the bench first waits for one sample change to synchronise. It then measures the clock count between later changes, which discards the shortened first step.

// File: rtl/saw_pkg.sv
package saw_pkg;
    // Step sequencer states
    typedef enum logic [1:0] {
        SEQ_OFF  = 2'd0,
        SEQ_EVEN = 2'd1,
        SEQ_ODD  = 2'd2
    } seq_state_t;

    // Register select codes
    localparam logic [1:0] SEL_RATE   = 2'd0;
    localparam logic [1:0] SEL_PER_LO = 2'd1;
    localparam logic [1:0] SEL_PER_HI = 2'd2;
endpackage

// File: rtl/saw_regs.sv
module saw_regs #(
    parameter int RATE_W   = 6,
    parameter int PERIOD_W = 12
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [1:0]          wr_sel,
    input  logic [7:0]          wr_data,
    output logic [RATE_W-1:0]   rate,
    output logic [PERIOD_W-1:0] period,
    output logic                enable
);
    import saw_pkg::*;
    localparam int HI_W = PERIOD_W - 8;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rate   <= '0;
            period <= '0;
            enable <= 1'b0;
        end else if (wr_en) begin
            unique case (wr_sel)
                SEL_RATE:   rate <= wr_data[RATE_W-1:0];
                SEL_PER_LO: period[7:0] <= wr_data;
                SEL_PER_HI: begin
                    period[PERIOD_W-1:8] <= wr_data[HI_W-1:0];
                    enable               <= wr_data[7];
                end
                default: ;
            endcase
        end
    end

    // R2: a write with enable bit clear disables the channel on the next cycle
    assert_enable_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel == SEL_PER_HI && !wr_data[7]) |=> !enable);
endmodule

// File: rtl/saw_divider.sv
module saw_divider #(
    parameter int PERIOD_W   = 12,
    parameter int SHIFT_MID  = 4,
    parameter int SHIFT_HIGH = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [PERIOD_W-1:0] period,
    input  logic                halt,
    input  logic                shift_mid,
    input  logic                shift_high,
    output logic                tick
);
    logic [PERIOD_W-1:0] cnt;
    logic [PERIOD_W-1:0] reload;

    // Effective period: larger shift wins
    always_comb begin
        if (shift_high)     reload = period >> SHIFT_HIGH;
        else if (shift_mid) reload = period >> SHIFT_MID;
        else                reload = period;
    end

    assign tick = !halt && (cnt == '0);

    always_ff @(posedge clk) begin
        if (!rst_n)            cnt <= '0;
        else if (!halt) begin
            if (cnt == '0)     cnt <= reload;
            else               cnt <= cnt - PERIOD_W'(1);
        end
    end

    assert_halt_freeze_R9: assert property (@(posedge clk) disable iff (!rst_n)
        halt |=> $stable(cnt));
    assert_reload_R3: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> (cnt == $past(reload)));
    assert_countdown_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!halt && cnt != '0) |=> (cnt == $past(cnt) - PERIOD_W'(1)));
endmodule

// File: rtl/saw_sequencer.sv
module saw_sequencer #(
    parameter int RATE_W = 6,
    parameter int ACC_W  = 8,
    parameter int OUT_W  = 5,
    parameter int ADDS   = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              tick,
    input  logic [RATE_W-1:0] rate,
    output logic [OUT_W-1:0]  sample
);
    import saw_pkg::*;
    localparam int CNT_W = $clog2(ADDS + 1);

    seq_state_t        state, state_nx;
    logic [ACC_W-1:0]  acc, acc_nx;
    logic [CNT_W-1:0]  adds, adds_nx;

    // Next-state and datapath decision
    always_comb begin
        state_nx = state;
        acc_nx   = acc;
        adds_nx  = adds;
        if (!enable) begin
            state_nx = SEQ_OFF;          // drop
            acc_nx   = '0;
            adds_nx  = '0;
        end else begin
            unique case (state)
                SEQ_OFF:  state_nx = SEQ_EVEN;           // arm
                SEQ_EVEN: if (tick) state_nx = SEQ_ODD;  // skip
                SEQ_ODD: if (tick) begin                 // act
                    state_nx = SEQ_EVEN;
                    if (adds == CNT_W'(ADDS)) begin
                        acc_nx  = '0;
                        adds_nx = '0;
                    end else begin
                        acc_nx  = acc + ACC_W'(rate);    // wraps mod 2^ACC_W
                        adds_nx = adds + CNT_W'(1);
                    end
                end
                default: state_nx = SEQ_OFF;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= SEQ_OFF;
            acc   <= '0;
            adds  <= '0;
        end else begin
            state <= state_nx;
            acc   <= acc_nx;
            adds  <= adds_nx;
        end
    end

    // Output
    always_comb begin
        sample = enable ? acc[ACC_W-1 -: OUT_W] : '0;
    end

    assert_disabled_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (acc == '0));
    assert_skip_holds_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && state == SEQ_EVEN) |=> $stable(acc));
    assert_clear_after_six_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && tick && state == SEQ_ODD && adds == CNT_W'(ADDS)) |=> (acc == '0));
    assert_add_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
        adds <= CNT_W'(ADDS));
endmodule

// File: rtl/saw_ramp_channel.sv
module saw_ramp_channel #(
    parameter int RATE_W   = 6,
    parameter int PERIOD_W = 12,
    parameter int ACC_W    = 8,
    parameter int OUT_W    = 5,
    parameter int ADDS     = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [1:0]       wr_sel,
    input  logic [7:0]       wr_data,
    input  logic             halt,
    input  logic             shift_x16,
    input  logic             shift_x256,
    output logic [OUT_W-1:0] sample
);
    logic [RATE_W-1:0]   rate;
    logic [PERIOD_W-1:0] period;
    logic                enable;
    logic                tick;

    saw_regs #(.RATE_W(RATE_W), .PERIOD_W(PERIOD_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .rate(rate), .period(period), .enable(enable)
    );

    saw_divider #(.PERIOD_W(PERIOD_W), .SHIFT_MID(4), .SHIFT_HIGH(8)) u_div (
        .clk(clk), .rst_n(rst_n), .period(period), .halt(halt),
        .shift_mid(shift_x16), .shift_high(shift_x256), .tick(tick)
    );

    saw_sequencer #(.RATE_W(RATE_W), .ACC_W(ACC_W), .OUT_W(OUT_W), .ADDS(ADDS)) u_seq (
        .clk(clk), .rst_n(rst_n), .enable(enable), .tick(tick),
        .rate(rate), .sample(sample)
    );

    assert_off_silent_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |-> (sample == '0));
    assert_halt_sample_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (halt && enable && $past(halt) && $past(enable)) |-> $stable(sample));
endmodule

// File: tb/saw_ramp_channel_test.sv
`timescale 1ns/1ps
module saw_ramp_channel_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [1:0] wr_sel = 2'd0;
    logic [7:0] wr_data = 8'd0;
    logic       halt = 1'b0;
    logic       shift_x16 = 1'b0;
    logic       shift_x256 = 1'b0;
    logic [4:0] sample;

    int n_checks = 0;
    int n_fail   = 0;

    always #4 clk = ~clk;   // 125 MHz

    saw_ramp_channel uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .halt(halt), .shift_x16(shift_x16),
        .shift_x256(shift_x256), .sample(sample)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; wr_en = 1'b0; halt = 1'b0; shift_x16 = 1'b0; shift_x256 = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic wr(input logic [1:0] s, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = s; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    function automatic int exp_step(input int a, input int k);
        return (((a * ((k % 14) / 2)) % 256) >> 3);
    endfunction

    // Measure clocks between two successive sample changes after one sync change
    task automatic measure(input string tag, input int expect_gap);
        logic [4:0] prev;
        int n;
        n = 0;
        prev = sample;
        while (sample == prev && n < 5000) begin @(negedge clk); n++; end
        for (int m = 0; m < 2; m++) begin
            prev = sample;
            n = 0;
            while (sample == prev && n < 5000) begin @(negedge clk); n++; end
            chk(tag, n, expect_gap);
        end
    endtask

    task automatic period_case(input string tag, input int per, input logic s16,
                               input logic s256, input int eff);
        do_reset();
        shift_x16 = s16; shift_x256 = s256;
        wr(2'd0, 8'd8);
        wr(2'd1, per[7:0]);
        wr(2'd2, {1'b1, 3'b000, per[11:8]});
        measure(tag, 2 * (eff + 1));
    endtask

    initial begin
        #1200000;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        do_reset();
        @(negedge clk);
        chk("R11 sample after reset", sample, 0);
        wr(2'd2, 8'h80);   // enable with rate 0 from reset
        repeat (6) begin @(negedge clk); chk("R11 reset rate zero", sample, 0); end
        wr(2'd2, 8'h00);

        // Full rate sweep, period 0: every clock is a tick (R1, R4-R7)
        do_reset();
        wr(2'd1, 8'h00);
        for (int a = 0; a < 64; a++) begin
            wr(2'd0, {a[1:0], a[5:0]});       // upper bits junk, R1
            wr(2'd3, 8'hFF);                  // ignored select, R2
            wr(2'd2, 8'h80);
            for (int k = 0; k < 17; k++) begin
                @(negedge clk);
                if (k >= 14)                      chk("R5 ramp repeat", sample, exp_step(a, k));
                else if (k % 2 == 1)              chk("R4 skip tick", sample, exp_step(a, k));
                else if (a * (k / 2) > 255)       chk("R7 wrap", sample, exp_step(a, k));
                else                              chk("R6 step value R1", sample, exp_step(a, k));
            end
            wr(2'd2, 8'h00);
            chk("R8 disable silences", sample, 0);
        end

        // Disable mid-ramp, re-enable restarts at step 0 (R8)
        wr(2'd0, 8'd8);
        wr(2'd2, 8'h80);
        repeat (7) @(negedge clk);
        chk("R8 pre-disable step 6", sample, 3);
        wr(2'd2, 8'h00);
        for (int i = 0; i < 10; i++) begin @(negedge clk); chk("R8 held off", sample, 0); end
        wr(2'd0, 8'd16);
        chk("R8 rate write while off", sample, 0);
        wr(2'd2, 8'h80);
        for (int k = 0; k < 6; k++) begin @(negedge clk); chk("R8 restart", sample, exp_step(16, k)); end
        wr(2'd2, 8'h00);

        // Halt freezes (R9)
        wr(2'd0, 8'd8);
        wr(2'd2, 8'h80);
        repeat (5) @(negedge clk);
        chk("R9 before halt", sample, 2);
        halt = 1'b1;
        for (int i = 0; i < 40; i++) begin @(negedge clk); chk("R9 frozen", sample, 2); end
        halt = 1'b0;
        @(negedge clk); chk("R9 resume step 5", sample, 2);
        @(negedge clk); chk("R9 resume step 6", sample, 3);
        wr(2'd2, 8'h00);

        // Divider period and shifts (R2, R3, R10)
        period_case("R3 period 5", 5, 1'b0, 1'b0, 5);
        period_case("R3 R2 period 9", 9, 1'b0, 1'b0, 9);
        period_case("R2 period high bits", 12'h103, 1'b0, 1'b0, 12'h103);
        period_case("R10 x16", 12'h0F3, 1'b1, 1'b0, 12'h00F);
        period_case("R10 x256", 12'h2FF, 1'b0, 1'b1, 2);
        period_case("R10 x256 over x16", 12'h2FF, 1'b1, 1'b1, 2);
        period_case("R10 x256 over x16 small", 12'h0F3, 1'b1, 1'b1, 0);

        $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end
endmodule